// File: doc/BRIEF.md
# Store-and-Forward Byte Packet Router

This block takes byte-wide packets on one input and delivers each to exactly one of four byte-wide output queues. Each queue belongs to an output port that is given its own 8-bit address, and a packet goes only to the port whose address equals the packet's destination byte. All logic runs on one clock.

On the input, a packet is sent in this order: a destination byte, a length byte that counts payload bytes (0 to 63), the payload, and one check byte. The check byte is the XOR of the destination, length and payload bytes. The router writes the length and payload into the target queue as they arrive, but keeps them hidden until the check byte has been compared. On a match the packet becomes readable in one step. On a mismatch the queue's write pointer is rolled back and an error pulse is raised. Packets with no matching port or with an illegal length are dropped and also raise an error pulse. A suspend output stops the sender whenever the target queue cannot take a packet of the largest size.

Each output is read through a show-ahead interface: a valid flag, the head byte, and a read enable.

Top module: `rtr_router`

## Requirements
- R1: A byte is taken from the input on a rising edge where in_valid is high and suspend is low. Taken bytes are read in the order destination, length, payload, check.
- R2: A port's queue shows a forwarded packet as its length byte first, then its payload bytes in arrival order. The destination and check bytes are not stored.
- R3: A packet is delivered only to the port whose port_addr entry equals its destination byte. The other ports' out_valid stays low. With port 0 at 8'hF8 and port 1 at 8'hF9, destination 8'hF9 reaches port 1 only and 8'hF8 reaches port 0 only.
- R4: Every length from 0 to 63 is legal. A length-0 packet is stored as its length byte alone.
- R5: If the check byte differs from the XOR of the destination, length and payload bytes, err is high in the cycle after the check byte is taken. In that case nothing of the packet becomes readable, and later packets to the same port read back intact.
- R6: out_valid of the target port rises in the cycle after the check byte is taken, and not earlier.
- R7: A destination that matches no port gives an err pulse in the cycle after the length byte is taken. The payload and check bytes are then consumed and discarded, and no port receives data.
- R8: A length byte above 63 gives an err pulse in the cycle after it is taken. The next taken byte is treated as the destination of a new packet.
- R9: After the destination byte is taken, suspend is high while the target queue holds more than DEPTH-64 committed bytes. It falls once reads bring the count down to DEPTH-64 or below, and the held length byte is then taken.
- R10: out_valid[p] is high while port p's queue holds committed bytes, and out_data[p] shows the head byte. A read enable while out_valid is high removes one byte.
- R11: After reset, out_valid, err and suspend are all low. err never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| port_addr | input | NPORT x 8 | address of each output port (must be distinct) |
| in_valid | input | 1 | sender presents a byte |
| in_data | input | 8 | input byte |
| suspend | output | 1 | sender must hold its byte |
| err | output | 1 | one-cycle drop indication |
| rd_en | input | NPORT | read enable per port |
| out_valid | output | NPORT | port queue holds committed data |
| out_data | output | NPORT x 8 | head byte per port |

## Verification
The checker assumes that the sender keeps in_valid high and in_data unchanged while suspend is high. It also assumes that the port addresses are distinct and stay constant. The stimulus tasks follow both rules: they only move to the next byte at a falling edge after an edge where suspend was low, and the addresses are fixed for the whole run. Under those rules the checker states the following. A newly committed packet only ever follows a taken byte. No two ports gain data in the same cycle. An error cycle never coincides with a release. err is never high for two cycles running.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
    localparam int BYTE_W     = 8;
    localparam int MAX_LEN    = 63;
    localparam int MAX_STORED = MAX_LEN + 1;
    localparam int CNT_W      = 6;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        PH_DEST,
        PH_LEN,
        PH_BODY,
        PH_CHECK,
        PH_SKIP
    } phase_e;

    function automatic logic len_legal(input byte_t l);
        return l <= byte_t'(MAX_LEN);
    endfunction
endpackage

// File: rtl/rtr_match.sv
module rtr_match
    import rtr_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  byte_t [NPORT-1:0] port_addr,
    input  byte_t             dest,
    output logic [NPORT-1:0]  hit_vec,
    output logic              hit
);
    for (genvar p = 0; p < NPORT; p++) begin : g_cmp
        assign hit_vec[p] = (port_addr[p] == dest);
    end
    assign hit = |hit_vec;
endmodule

// File: rtl/rtr_fifo.sv
module rtr_fifo
    import rtr_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int ROOM  = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  commit,
    input  logic  abort,
    input  logic  rd_en,
    output logic  out_valid,
    output byte_t out_data,
    output logic  room
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH - ROOM);

    byte_t       mem [DEPTH];
    logic [AW:0] wr_spec, wr_com, rd_ptr;
    logic [AW:0] used;

    assign used      = wr_com - rd_ptr;
    assign out_valid = (used != '0);
    assign out_data  = mem[rd_ptr[AW-1:0]];
    assign room      = (used <= LIMIT);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_spec[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_spec <= '0;
            wr_com  <= '0;
            rd_ptr  <= '0;
        end else begin
            if (abort)         wr_spec <= wr_com;
            else if (wr_en)    wr_spec <= wr_spec + 1'b1;
            if (commit)        wr_com  <= wr_spec;
            if (rd_en && out_valid) rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/rtr_ctrl.sv
module rtr_ctrl
    import rtr_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  byte_t            in_data,
    input  logic [NPORT-1:0] hit_vec,
    input  logic             hit,
    input  logic [NPORT-1:0] room_vec,
    output byte_t            dest_q,
    output logic             suspend,
    output logic [NPORT-1:0] wr_vec,
    output byte_t            wr_data,
    output logic [NPORT-1:0] commit_vec,
    output logic [NPORT-1:0] abort_vec,
    output logic             err
);
    phase_e           ph;
    byte_t            chk;
    logic [CNT_W-1:0] remain;
    logic             accept, len_ok, chk_good, target_room;

    assign target_room = |(hit_vec & room_vec);
    assign suspend     = (ph == PH_LEN) && hit && !target_room;
    assign accept      = in_valid && !suspend;
    assign len_ok      = len_legal(in_data);
    assign chk_good    = (chk == in_data);
    assign wr_data     = in_data;

    always_comb begin
        wr_vec     = '0;
        commit_vec = '0;
        abort_vec  = '0;
        if (accept) begin
            if ((ph == PH_LEN && len_ok && hit) || ph == PH_BODY) wr_vec = hit_vec;
            if (ph == PH_CHECK) begin
                if (chk_good) commit_vec = hit_vec;
                else          abort_vec  = hit_vec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_DEST;
            chk    <= '0;
            remain <= '0;
            dest_q <= '0;
            err    <= 1'b0;
        end else begin
            err <= 1'b0;
            if (accept) begin
                case (ph)
                    PH_DEST: begin
                        dest_q <= in_data;
                        chk    <= in_data;
                        ph     <= PH_LEN;
                    end
                    PH_LEN: begin
                        chk    <= chk ^ in_data;
                        remain <= in_data[CNT_W-1:0];
                        if (!len_ok) begin
                            err <= 1'b1;
                            ph  <= PH_DEST;
                        end else if (!hit) begin
                            err <= 1'b1;
                            ph  <= PH_SKIP;
                        end else if (in_data == '0) begin
                            ph <= PH_CHECK;
                        end else begin
                            ph <= PH_BODY;
                        end
                    end
                    PH_BODY: begin
                        chk    <= chk ^ in_data;
                        remain <= remain - 1'b1;
                        if (remain == CNT_W'(1)) ph <= PH_CHECK;
                    end
                    PH_CHECK: begin
                        if (!chk_good) err <= 1'b1;
                        ph <= PH_DEST;
                    end
                    PH_SKIP: begin
                        if (remain == '0) ph <= PH_DEST;
                        else              remain <= remain - 1'b1;
                    end
                    default: ph <= PH_DEST;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtr_router.sv
module rtr_router
    import rtr_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DEPTH = 128
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0][7:0]   port_addr,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    output logic                    suspend,
    output logic                    err,
    input  logic [NPORT-1:0]        rd_en,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT-1:0][7:0]   out_data
);
    byte_t            dest_q, wr_data;
    logic [NPORT-1:0] hit_vec, room_vec, wr_vec, commit_vec, abort_vec;
    logic             hit;

    rtr_match #(.NPORT(NPORT)) u_match (
        .port_addr (port_addr),
        .dest      (dest_q),
        .hit_vec   (hit_vec),
        .hit       (hit)
    );

    rtr_ctrl #(.NPORT(NPORT)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .hit_vec    (hit_vec),
        .hit        (hit),
        .room_vec   (room_vec),
        .dest_q     (dest_q),
        .suspend    (suspend),
        .wr_vec     (wr_vec),
        .wr_data    (wr_data),
        .commit_vec (commit_vec),
        .abort_vec  (abort_vec),
        .err        (err)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_q
        rtr_fifo #(.DEPTH(DEPTH), .ROOM(MAX_STORED)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_vec[p]),
            .wr_data   (wr_data),
            .commit    (commit_vec[p]),
            .abort     (abort_vec[p]),
            .rd_en     (rd_en[p]),
            .out_valid (out_valid[p]),
            .out_data  (out_data[p]),
            .room      (room_vec[p])
        );
    end
endmodule

// File: rtl/rtr_router_chk.sv
module rtr_router_chk #(
    parameter int NPORT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [7:0]       in_data,
    input logic             suspend,
    input logic             err,
    input logic [NPORT-1:0] out_valid
);
    logic [NPORT-1:0] prev_valid;
    logic [NPORT-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) prev_valid <= '0;
        else     prev_valid <= out_valid;
    end
    assign rise = out_valid & ~prev_valid;

    // R11: err is a single-cycle pulse
    a_r11_err_single: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    // R6: data is released only right after a byte was taken
    a_r6_release_after_take: assert property (@(posedge clk) disable iff (rst)
        (|rise) |-> $past(in_valid && !suspend));

    // R3: one packet reaches one port
    a_r3_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rise));

    // R5: a failed packet is never released
    a_r5_no_release_on_err: assert property (@(posedge clk) disable iff (rst)
        err |-> (rise == '0));

    // R9: input assumption, sender holds while suspended
    a_r9_hold_while_suspended: assert property (@(posedge clk) disable iff (rst)
        (suspend && in_valid) |=> (in_valid && $stable(in_data)));
endmodule

bind rtr_router rtr_router_chk #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .suspend   (suspend),
    .err       (err),
    .out_valid (out_valid)
);

// File: tb/sim_rtr_router.sv
module sim_rtr_router;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 4;
    localparam int DEPTH = 128;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NPORT-1:0][7:0] port_addr;
    logic                  in_valid = 1'b0;
    logic [7:0]            in_data = '0;
    logic                  suspend, err;
    logic [NPORT-1:0]      rd_en = '0;
    logic [NPORT-1:0]      out_valid;
    logic [NPORT-1:0][7:0] out_data;

    int n_checks = 0;
    int n_errors = 0;
    logic err_after_len, err_after_chk;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign port_addr = {8'h7E, 8'h21, 8'hF9, 8'hF8};

    rtr_router #(.NPORT(NPORT), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .port_addr(port_addr),
        .in_valid(in_valid), .in_data(in_data),
        .suspend(suspend), .err(err),
        .rd_en(rd_en), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [7:0] pay(input int seed, input int k);
        return 8'((seed * 11) + (k * 37) + 5);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R1: drive at a falling edge, taken at the first rising edge with suspend low
    task automatic put_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (suspend) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_pkt(input logic [7:0] dest, input int len, input int seed,
                            input logic corrupt, input logic fresh);
        logic [7:0] x;
        x = dest ^ 8'(len);
        put_byte(dest);
        put_byte(8'(len));
        err_after_len = err;
        for (int k = 0; k < len; k++) begin
            put_byte(pay(seed, k));
            x = x ^ pay(seed, k);
        end
        if (fresh) check("R6 nothing visible before check byte", int'(out_valid), 0);
        put_byte(corrupt ? ~x : x);
        err_after_chk = err;
        in_valid = 1'b0;
    endtask

    task automatic read_pkt(input int p, input int len, input int seed, input logic last);
        for (int i = 0; i <= len; i++) begin
            check("R10 out_valid while reading", int'(out_valid[p]), 1);
            check("R2 byte content", int'(out_data[p]), (i == 0) ? len : int'(pay(seed, i - 1)));
            rd_en[p] = 1'b1;
            @(negedge clk);
            rd_en[p] = 1'b0;
        end
        if (last) check("R10 queue empty after read", int'(out_valid[p]), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int lens[6];
        lens = '{0, 1, 2, 31, 62, 63};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check("R11 reset out_valid", int'(out_valid), 0);
        check("R11 reset err", int'(err), 0);
        check("R11 reset suspend", int'(suspend), 0);

        // R3 R4 R2: sweep ports and lengths
        for (int p = 0; p < NPORT; p++) begin
            for (int li = 0; li < 6; li++) begin
                send_pkt(port_addr[p], lens[li], p * 10 + li, 1'b0, 1'b1);
                check("R5 no err on good packet", int'(err_after_chk), 0);
                check("R3 only target port valid", int'(out_valid), 1 << p);
                read_pkt(p, lens[li], p * 10 + li, 1'b1);
            end
        end

        // R3: example mapping, F9 to port 1 and F8 to port 0, read in reverse
        send_pkt(8'hF9, 3, 77, 1'b0, 1'b1);
        check("R3 F9 goes to port 1", int'(out_valid), 4'b0010);
        send_pkt(8'hF8, 4, 78, 1'b0, 1'b0);
        check("R3 F8 goes to port 0", int'(out_valid), 4'b0011);
        read_pkt(0, 4, 78, 1'b1);
        read_pkt(1, 3, 77, 1'b1);

        // R5: bad check byte dropped, rollback keeps later packet intact
        send_pkt(port_addr[2], 9, 40, 1'b1, 1'b1);
        check("R5 err after bad check", int'(err_after_chk), 1);
        check("R5 nothing released", int'(out_valid), 0);
        @(negedge clk);
        check("R11 err falls", int'(err), 0);
        send_pkt(port_addr[2], 6, 41, 1'b0, 1'b1);
        check("R5 later packet released", int'(out_valid), 4'b0100);
        read_pkt(2, 6, 41, 1'b1);

        // R7: unmatched destination
        send_pkt(8'h00, 4, 50, 1'b0, 1'b1);
        check("R7 err after length byte", int'(err_after_len), 1);
        check("R7 no err at end", int'(err_after_chk), 0);
        check("R7 no port receives", int'(out_valid), 0);

        // R8: illegal length, next byte starts a new packet
        put_byte(port_addr[0]);
        put_byte(8'd64);
        check("R8 err after bad length", int'(err), 1);
        in_valid = 1'b0;
        send_pkt(port_addr[0], 2, 60, 1'b0, 1'b1);
        check("R8 next packet ok", int'(out_valid), 4'b0001);
        read_pkt(0, 2, 60, 1'b1);

        // R9: fill port 3 with two full packets, third must be suspended
        send_pkt(port_addr[3], 63, 91, 1'b0, 1'b1);
        check("R9 no suspend after one full packet", int'(suspend), 0);
        send_pkt(port_addr[3], 63, 92, 1'b0, 1'b0);
        fork
            send_pkt(port_addr[3], 5, 93, 1'b0, 1'b0);
            begin
                repeat (4) @(negedge clk);
                check("R9 suspend high with full queue", int'(suspend), 1);
                read_pkt(3, 63, 91, 1'b0);
                check("R9 suspend released after drain", int'(suspend), 0);
            end
        join
        check("R9 suspended packet error-free", int'(err_after_chk), 0);
        read_pkt(3, 63, 92, 1'b0);
        read_pkt(3, 5, 93, 1'b1);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule